// File: doc/BRIEF.md
# Latched Memory Window Decoder

This block sits between a 16-bit expansion bus and a memory-mapped peripheral. It turns the bus address into three decisions: whether the cycle targets the peripheral's shared RAM, whether it targets an optional boot ROM, and whether the peripheral claims the cycle as a 16-bit memory transfer. The 16-bit claim is active low. The address first passes through a level-sensitive latch. The latch is open while the address-latch-enable input is high and holds its contents while that input is low. Decoding therefore keeps working after the bus has dropped the early address lines.

Two inputs choose the window sizes. The first is a ROM-enable strap, active low. The second is a decode-mode bit. The RAM window is always 2K. The ROM window is 8K and exists only while the strap is low. The 16-bit-claim window is anchored on the RAM base address. It is 2K in most combinations and widens to 128K when the strap is high and the mode bit is 0. Each window is aligned to its own size. A window matches when the latched address and that window's base agree on every bit above the window size. If the ROM and RAM windows overlap, ROM wins.

Top module: `mem_window_decoder`

## Requirements
- R1: While `ale` is high, all outputs follow `addr` combinationally, with no clock involved.
- R2: While `ale` is low, changes on `addr` have no effect on any output. The address held is the one present when `ale` fell.
- R3: `ram_sel` is 1 when bits [AW-1:11] of the latched address equal the same bits of `ram_base`, unless ROM claims the address (see R9). This holds in every strap and mode combination.
- R4: When `rom_en_n` is 0, `rom_sel` is 1 when bits [AW-1:13] of the latched address equal the same bits of `rom_base`.
- R5: When `rom_en_n` is 1, `rom_sel` stays 0 for every address.
- R6: When `rom_en_n` is 0, `cs16_n` is 0 exactly when bits [AW-1:11] of the latched address match `ram_base`, whatever the value of `dec_mode`.
- R7: When `rom_en_n` is 1 and `dec_mode` is 0, `cs16_n` is 0 exactly when bits [AW-1:17] of the latched address match `ram_base`. This is a 128K window.
- R8: When `rom_en_n` is 1 and `dec_mode` is 1, `cs16_n` is 0 exactly when bits [AW-1:11] of the latched address match `ram_base`.
- R9: `ram_sel` and `rom_sel` are never 1 together. When both windows contain the address, only `rom_sel` is 1.
- R10: With `ale` held at 1 for a whole sequence, the decode of each address is correct on its own and does not depend on earlier addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ale | input | 1 | Address latch enable: latch open when 1, holding when 0 |
| addr | input | AW (24) | Bus address |
| ram_base | input | AW (24) | Base of the RAM window; also anchors the 16-bit-claim window |
| rom_base | input | AW (24) | Base of the ROM window |
| rom_en_n | input | 1 | ROM-enable strap, active low |
| dec_mode | input | 1 | Decode-mode bit; picks the narrow 16-bit-claim window when the strap is high |
| ram_sel | output | 1 | Address falls in the RAM window |
| rom_sel | output | 1 | Address falls in the enabled ROM window |
| cs16_n | output | 1 | Active-low 16-bit memory-cycle claim |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 2K RAM window, an 8K ROM window and a 128K wide 16-bit-claim window. A 24-bit address space leaves room for three window sizes, so a randomly chosen base can sit inside another window's span or apart from it. Placing random addresses near either base reaches both sides of each window edge. The random traffic also reaches the ROM-over-RAM overlap and the held-latch cases in which `addr` wanders outside every window.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  // Which sizing profile the strap and mode bit select.
  typedef enum logic [1:0] {
    PROF_ROM_NARROW = 2'd0,  // ROM enabled: 16-bit claim 2K, ROM 8K
    PROF_WIDE16     = 2'd1,  // ROM off, mode 0: 16-bit claim 128K
    PROF_NARROW16   = 2'd2   // ROM off, mode 1: 16-bit claim 2K
  } prof_e;

  function automatic prof_e pick_profile(input logic rom_en_n, input logic dec_mode);
    if (!rom_en_n)     return PROF_ROM_NARROW;
    else if (!dec_mode) return PROF_WIDE16;
    else               return PROF_NARROW16;
  endfunction

  function automatic logic prof_rom_allowed(input prof_e p);
    return (p == PROF_ROM_NARROW);
  endfunction

  function automatic logic prof_wide16(input prof_e p);
    return (p == PROF_WIDE16);
  endfunction

endpackage

// File: rtl/mwd_addr_latch.sv
module mwd_addr_latch #(
  parameter int AW = 24
) (
  input  logic          ale,
  input  logic [AW-1:0] addr_d,
  output logic [AW-1:0] addr_q
);

  logic [AW-1:0] held;

  // Level-sensitive: open while ale is high, closed while low.
  always_latch begin
    if (ale) held <= addr_d;
  end

  assign addr_q = held;

endmodule

// File: rtl/mwd_window_match.sv
module mwd_window_match #(
  parameter int AW = 24,
  parameter int LG = 11
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit
);

  generate
    if (LG >= AW) begin : g_whole
      // Window covers the entire address space.
      assign hit = 1'b1;
    end else if (LG <= 0) begin : g_exact
      assign hit = (addr == base);
    end else begin : g_upper
      localparam int TAG_W = AW - LG;
      logic [TAG_W-1:0] addr_tag;
      logic [TAG_W-1:0] base_tag;
      assign addr_tag = addr[AW-1:LG];
      assign base_tag = base[AW-1:LG];
      assign hit      = (addr_tag == base_tag);
    end
  endgenerate

endmodule

// File: rtl/mwd_profile.sv
module mwd_profile (
  input  logic rom_en_n,
  input  logic dec_mode,
  output logic rom_allow,
  output logic wide16
);
  import mwd_pkg::*;

  prof_e prof;

  always_comb begin
    prof      = pick_profile(rom_en_n, dec_mode);
    rom_allow = prof_rom_allowed(prof);
    wide16    = prof_wide16(prof);
  end

  // R5: a high strap must never let the ROM window through.
  always_comb begin
    assert_rom_gate_R5: assert (!(rom_en_n && rom_allow))
      else $error("ROM window enabled while strap is high");
  end

endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder #(
  parameter int AW        = 24,
  parameter int RAM_LG    = 11,
  parameter int ROM_LG    = 13,
  parameter int WIDE16_LG = 17
) (
  input  logic          ale,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ram_base,
  input  logic [AW-1:0] rom_base,
  input  logic          rom_en_n,
  input  logic          dec_mode,
  output logic          ram_sel,
  output logic          rom_sel,
  output logic          cs16_n
);

  // The narrow 16-bit claim window has the same size as the RAM window.
  localparam int NARROW16_LG = RAM_LG;

  logic [AW-1:0] lat_addr;
  logic          ram_hit_raw;
  logic          rom_hit_raw;
  logic          c16_narrow_hit;
  logic          c16_wide_hit;
  logic          rom_allow;
  logic          wide16;
  logic          rom_claim;
  logic          c16_claim;

  mwd_addr_latch #(.AW(AW)) u_latch (
    .ale    (ale),
    .addr_d (addr),
    .addr_q (lat_addr)
  );

  mwd_profile u_prof (
    .rom_en_n  (rom_en_n),
    .dec_mode  (dec_mode),
    .rom_allow (rom_allow),
    .wide16    (wide16)
  );

  mwd_window_match #(.AW(AW), .LG(RAM_LG)) u_ram_win (
    .addr (lat_addr), .base (ram_base), .hit (ram_hit_raw)
  );

  mwd_window_match #(.AW(AW), .LG(ROM_LG)) u_rom_win (
    .addr (lat_addr), .base (rom_base), .hit (rom_hit_raw)
  );

  mwd_window_match #(.AW(AW), .LG(NARROW16_LG)) u_c16n_win (
    .addr (lat_addr), .base (ram_base), .hit (c16_narrow_hit)
  );

  mwd_window_match #(.AW(AW), .LG(WIDE16_LG)) u_c16w_win (
    .addr (lat_addr), .base (ram_base), .hit (c16_wide_hit)
  );

  always_comb begin
    rom_claim = rom_allow & rom_hit_raw;
    c16_claim = wide16 ? c16_wide_hit : c16_narrow_hit;
  end

  assign rom_sel = rom_claim;
  assign ram_sel = ram_hit_raw & ~rom_claim;   // ROM takes precedence
  assign cs16_n  = ~c16_claim;

  // R9: the two memory selects are mutually exclusive.
  always_comb begin
    assert_sel_exclusive_R9: assert (!(ram_sel && rom_sel))
      else $error("RAM and ROM selected together");
  end

  // R7: the wide claim window must contain the narrow one (same base).
  always_comb begin
    assert_wide_superset_R7: assert (!c16_narrow_hit || c16_wide_hit)
      else $error("narrow 16-bit window outside wide window");
  end

  // R6 / R8: any RAM window hit must also raise the 16-bit claim.
  always_comb begin
    assert_ram_claims16_R6: assert (!ram_hit_raw || !cs16_n)
      else $error("RAM hit without 16-bit claim");
  end

endmodule

// File: tb/test_mem_window_decoder.sv
module test_mem_window_decoder;

  localparam int AW = 24;
  localparam int TCK = 4;   // 250 MHz

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ale;
  logic [AW-1:0] addr;
  logic [AW-1:0] ram_base;
  logic [AW-1:0] rom_base;
  logic          rom_en_n;
  logic          dec_mode;
  logic          ram_sel;
  logic          rom_sel;
  logic          cs16_n;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit closed = 1'b0;
  logic [AW-1:0] model_q = '0;

  always #(TCK/2) clk = ~clk;

  mem_window_decoder i_mem_window_decoder (
    .ale(ale), .addr(addr), .ram_base(ram_base), .rom_base(rom_base),
    .rom_en_n(rom_en_n), .dec_mode(dec_mode),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .cs16_n(cs16_n)
  );

  // Window test by masking: clear the offset bits, compare what is left.
  function automatic bit in_win(input logic [AW-1:0] a, input logic [AW-1:0] b, input int lg);
    logic [AW-1:0] keep;
    keep = ~((({{(AW-1){1'b0}}, 1'b1}) << lg) - 1'b1);
    return ((a ^ b) & keep) == '0;
  endfunction

  function automatic bit exp_rom(input logic [AW-1:0] a);
    return (rom_en_n == 1'b0) && in_win(a, rom_base, 13);
  endfunction

  function automatic bit exp_ram(input logic [AW-1:0] a);
    return in_win(a, ram_base, 11) && !exp_rom(a);
  endfunction

  function automatic bit exp_cs16n(input logic [AW-1:0] a);
    int lg;
    lg = (rom_en_n && !dec_mode) ? 17 : 11;
    return !in_win(a, ram_base, lg);
  endfunction

  function automatic string c16_tag();
    if (!rom_en_n) return "R6";
    else if (!dec_mode) return "R7";
    else return "R8";
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (addr=%h latched=%h ram_base=%h rom_base=%h strap=%0b mode=%0b)",
               req, what, act, exp, addr, model_q, ram_base, rom_base, rom_en_n, dec_mode);
    end
  endtask

  // Drive on the falling edge, settle, compare all three outputs.
  task automatic drive(input logic a_le, input logic [AW-1:0] a);
    @(negedge clk);
    ale  = a_le;
    addr = a;
    if (a_le) model_q = a;
    #1;
  endtask

  task automatic check_all(input string req);
    chk(req, "ram_sel", ram_sel, exp_ram(model_q));
    chk(req, "rom_sel", rom_sel, exp_rom(model_q));
    chk(req, "cs16_n",  cs16_n,  exp_cs16n(model_q));
  endtask

  task automatic close_run();
    if (!closed) begin
      closed = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual=hung expected=finished");
    close_run();
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20250611));
    ale = 1'b1; addr = '0;
    ram_base = 24'h0C0000; rom_base = 24'h0D0000;
    rom_en_n = 1'b1; dec_mode = 1'b1;
    model_q = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;

    // Idle state after reset: address 0 lies outside every window.
    drive(1'b1, 24'h000000);
    check_all("R3");

    // R3: RAM window edges.
    drive(1'b1, 24'h0C07FF); check_all("R3");
    drive(1'b1, 24'h0C0800); check_all("R3");
    drive(1'b1, 24'h0BFFFF); check_all("R3");

    // R4: ROM window with strap low.
    rom_en_n = 1'b0;
    drive(1'b1, 24'h0D1FFF); check_all("R4");
    drive(1'b1, 24'h0D2000); check_all("R4");
    drive(1'b1, 24'h0C0010); check_all("R6");

    // R5: same ROM address with strap high.
    rom_en_n = 1'b1;
    drive(1'b1, 24'h0D0004); check_all("R5");
    chk("R5", "rom_sel forced", rom_sel, 1'b0);

    // R7: 128K claim window, outside the RAM window.
    dec_mode = 1'b0;
    drive(1'b1, 24'h0DF000); check_all("R7");
    chk("R7", "cs16_n wide", cs16_n, 1'b0);
    drive(1'b1, 24'h0E0000); check_all("R7");
    // R8: same address, narrow claim.
    dec_mode = 1'b1;
    drive(1'b1, 24'h0DF000); check_all("R8");
    chk("R8", "cs16_n narrow", cs16_n, 1'b1);

    // R9: overlapping ROM and RAM windows, ROM wins.
    rom_en_n = 1'b0; rom_base = 24'h0C0000;
    drive(1'b1, 24'h0C0100); check_all("R9");
    chk("R9", "rom wins", rom_sel, 1'b1);
    chk("R9", "ram yields", ram_sel, 1'b0);
    rom_base = 24'h0D0000; rom_en_n = 1'b1;

    // R2: held latch ignores address changes.
    drive(1'b1, 24'h0C0123); check_all("R1");
    drive(1'b0, 24'h3F0000); check_all("R2");
    chk("R2", "ram_sel held", ram_sel, 1'b1);
    drive(1'b0, 24'h000000); check_all("R2");
    // R1: reopening the latch follows the bus again.
    drive(1'b1, 24'h3F0000); check_all("R1");
    chk("R1", "ram_sel follows", ram_sel, 1'b0);

    // R10: latch enable tied high across a sweep.
    for (int k = 0; k < 64; k++) begin
      drive(1'b1, 24'h0C0000 + 24'(k * 24'h0400)); check_all("R10");
    end

    // Random traffic near the bases, mixed strap, mode and latch activity.
    for (int it = 0; it < 3000; it++) begin
      if (it % 200 == 0) begin
        ram_base = 24'($urandom) & 24'hFFF800;
        rom_base = ($urandom % 3 == 0) ? (ram_base & 24'hFFE000)
                                       : (24'($urandom) & 24'hFFE000);
        rom_en_n = 1'($urandom);
        dec_mode = 1'($urandom);
      end
      case ($urandom % 4)
        0: a = ram_base ^ (24'($urandom) & 24'h000FFF);
        1: a = rom_base ^ (24'($urandom) & 24'h003FFF);
        2: a = ram_base ^ (24'($urandom) & 24'h03FFFF);
        default: a = 24'($urandom);
      endcase
      drive(($urandom % 4) != 0, a);
      check_all(ale ? "R3" : "R2");
      chk(c16_tag(), "cs16_n rnd", cs16_n, exp_cs16n(model_q));
      chk(rom_en_n ? "R5" : "R4", "rom_sel rnd", rom_sel, exp_rom(model_q));
      chk("R9", "exclusive", ram_sel & rom_sel, 1'b0);
    end

    close_run();
  end

endmodule